// File: doc/BRIEF.md
# Single-Cycle Integer Core with Post-Increment Store

This block is a 32-bit single-cycle processor core for a small load/store instruction subset. Each clock it fetches one instruction from an instruction memory port, decodes it and executes it completely. It updates the program counter, the register file and, for stores, the data memory. The instruction and data memories are outside the block. They are read combinationally through plain address/data ports, and the data memory is written on the rising clock edge when the store strobe is high.

Besides three-operand arithmetic and logic, compare-less-than, word load, word store and branch-if-equal, the core runs a post-increment store. This store writes a register to memory at base plus offset. In the same cycle it writes the base register back with its old value plus four, so a loop can walk through an array one word per instruction. The increment comes from a small constant adder on the base read port. The decoder steers the register-file write address and write data through extra multiplexer legs. No second ALU, register file or memory port is added.

Top module: `autoinc_core`

## Requirements
- R1: `rst` is synchronous and active high. A clock edge with `rst` high sets the PC (`imem_addr`) to 0. While `rst` is high, `dmem_we` is 0 and no register is written. Register contents are not cleared by reset.
- R2: An R-type instruction (opcode 0x00, bits 10:6 zero) with function code 0x20, 0x22, 0x24 or 0x25 writes rs+rt, rs-rt, rs AND rt or rs OR rt to register rd. The fields are rs = bits 25:21, rt = bits 20:16 and rd = bits 15:11.
- R3: R-type function 0x2A writes 1 to rd when rs is less than rt as signed 32-bit values, otherwise 0.
- R4: A load (opcode 0x23) drives `dmem_addr` = rs + sign-extended bits 15:0 with `dmem_re` high, and writes `dmem_rdata` to rt.
- R5: A store (opcode 0x2B) drives `dmem_we` high, `dmem_addr` = rs + sign-extended offset and `dmem_wdata` = rt.
- R6: The post-increment store (opcode 0x2F, same field layout as the store) writes rt to rs + sign-extended offset, using the value rs held before the instruction. In the same cycle it writes rs+4 into rs, for any offset.
- R7: Register 0 always reads as 0 and writes to it are dropped. This includes a post-increment store with base register 0, whose memory address is then the offset alone.
- R8: A branch (opcode 0x04) sets the next PC to PC+4 + (sign-extended offset × 4) when rs equals rt, otherwise to PC+4.
- R9: Every instruction completes in one clock. Outside reset, each non-branch instruction moves the PC to PC+4.
- R10: An unknown opcode, or an R-type with an unknown function code or nonzero bits 10:6, writes neither a register nor memory and moves the PC to PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_data | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Byte address for data load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, memory written at the rising edge |
| dmem_re | output | 1 | Load indicator |
| dmem_rdata | input | 32 | Data word at `dmem_addr` |

## Verification
Random programs mixing all instruction kinds, with register values loaded from random memory words, are run against an instruction-level model. The PC and every store are compared each cycle, so a wrong register result shows up in a later store's data or address. Directed sequences separate the cases that random code hits rarely. A signed compare of a negative value against a positive one distinguishes signed from unsigned compare. Two back-to-back post-increment stores on the same base, one with a nonzero offset, distinguish old-base addressing from new-base addressing and a fixed +4 step from an offset-sized step. Base register 0 distinguishes dropped from applied writes to register 0. Taken and not-taken branches, with stores placed in the skipped slots, and unsupported opcodes and function codes followed by a store of the untouched register show that nothing leaks from a suppressed instruction. A reset in mid-run followed by a dump of all registers shows that reset restarts fetch at 0 and leaves register contents intact.

// File: rtl/sca_pkg.sv
package sca_pkg;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;
  localparam logic [5:0] OPC_SWINC = 6'h2F;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_AND = 3'd0,
    ALU_OR  = 3'd1,
    ALU_ADD = 3'd2,
    ALU_SUB = 3'd3,
    ALU_SLT = 3'd4
  } alu_fn_e;

  typedef struct packed {
    logic       reg_dst;
    logic       alu_src;
    logic       mem_to_reg;
    logic       reg_write;
    logic       mem_read;
    logic       mem_write;
    logic       branch;
    logic [1:0] alu_op;
    logic       inc_base;
  } ctrl_t;

endpackage

// File: rtl/sca_main_ctrl.sv
module sca_main_ctrl
  import sca_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    case (opcode)
      OPC_RTYPE: begin
        ctrl.reg_dst   = 1'b1;
        ctrl.reg_write = 1'b1;
        ctrl.alu_op    = 2'b10;
      end
      OPC_LW: begin
        ctrl.alu_src    = 1'b1;
        ctrl.mem_to_reg = 1'b1;
        ctrl.reg_write  = 1'b1;
        ctrl.mem_read   = 1'b1;
      end
      OPC_SW: begin
        ctrl.alu_src   = 1'b1;
        ctrl.mem_write = 1'b1;
      end
      OPC_SWINC: begin
        ctrl.alu_src   = 1'b1;
        ctrl.mem_write = 1'b1;
        ctrl.reg_write = 1'b1;
        ctrl.inc_base  = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = 2'b01;
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/sca_alu_ctrl.sv
module sca_alu_ctrl
  import sca_pkg::*;
(
  input  logic [1:0] alu_op,
  input  logic [5:0] funct,
  input  logic [4:0] shamt,
  output alu_fn_e    fn,
  output logic       funct_ok
);

  always_comb begin
    fn       = ALU_ADD;
    funct_ok = 1'b1;
    case (alu_op)
      2'b00: fn = ALU_ADD;
      2'b01: fn = ALU_SUB;
      default: begin
        funct_ok = (shamt == '0);
        case (funct)
          FN_ADD: fn = ALU_ADD;
          FN_SUB: fn = ALU_SUB;
          FN_AND: fn = ALU_AND;
          FN_OR:  fn = ALU_OR;
          FN_SLT: fn = ALU_SLT;
          default: funct_ok = 1'b0;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/sca_alu.sv
module sca_alu
  import sca_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output logic         zero
);

  always_comb begin
    case (fn)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sca_regfile.sv
module sca_regfile #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 32,
  parameter int unsigned NRD   = 2,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [W-1:0]            wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][W-1:0]   rdata
);

  logic [W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) begin
      store_q[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = (raddr[p] == '0) ? '0 : store_q[raddr[p]];
  end

endmodule

// File: rtl/autoinc_core.sv
module autoinc_core
  import sca_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned REG_COUNT = 32,
  localparam int unsigned RAW        = $clog2(REG_COUNT),
  localparam int unsigned WORD_BYTES = XLEN / 8
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_data,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  output logic            dmem_re,
  input  logic [XLEN-1:0] dmem_rdata
);

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_next, pc_plus, br_target;

  logic [5:0]     opcode, funct;
  logic [4:0]     shamt;
  logic [RAW-1:0] rs, rt, rd;
  logic [XLEN-1:0] imm_ext;

  ctrl_t   ctrl;
  alu_fn_e alu_fn;
  logic    funct_ok;

  logic [1:0][RAW-1:0]  rf_raddr;
  logic [1:0][XLEN-1:0] rf_rdata;
  logic [XLEN-1:0] rd_a, rd_b;
  logic            rf_we;
  logic [RAW-1:0]  rf_waddr;
  logic [XLEN-1:0] rf_wdata;
  logic [XLEN-1:0] base_inc;

  logic [XLEN-1:0] alu_b, alu_y;
  logic            alu_zero;

  // instruction fields
  assign opcode  = imem_data[31:26];
  assign rs      = imem_data[21 +: RAW];
  assign rt      = imem_data[16 +: RAW];
  assign rd      = imem_data[11 +: RAW];
  assign shamt   = imem_data[10:6];
  assign funct   = imem_data[5:0];
  assign imm_ext = {{(XLEN-16){imem_data[15]}}, imem_data[15:0]};

  sca_main_ctrl u_main_ctrl (
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  sca_alu_ctrl u_alu_ctrl (
    .alu_op   (ctrl.alu_op),
    .funct    (funct),
    .shamt    (shamt),
    .fn       (alu_fn),
    .funct_ok (funct_ok)
  );

  assign rf_raddr[0] = rs;
  assign rf_raddr[1] = rt;
  assign rd_a        = rf_rdata[0];
  assign rd_b        = rf_rdata[1];

  sca_regfile #(
    .W     (XLEN),
    .DEPTH (REG_COUNT),
    .NRD   (2)
  ) u_regfile (
    .clk   (clk),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .raddr (rf_raddr),
    .rdata (rf_rdata)
  );

  assign alu_b = ctrl.alu_src ? imm_ext : rd_b;

  sca_alu #(
    .W (XLEN)
  ) u_alu (
    .a    (rd_a),
    .b    (alu_b),
    .fn   (alu_fn),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // constant incrementer on the base read port
  assign base_inc = rd_a + XLEN'(WORD_BYTES);

  // write-back steering
  always_comb begin
    if (ctrl.inc_base) begin
      rf_waddr = rs;
      rf_wdata = base_inc;
    end else begin
      rf_waddr = ctrl.reg_dst ? rd : rt;
      rf_wdata = ctrl.mem_to_reg ? dmem_rdata : alu_y;
    end
  end

  assign rf_we = ctrl.reg_write & ~rst & ((ctrl.alu_op != 2'b10) | funct_ok);

  // data memory port
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rd_b;
  assign dmem_we    = ctrl.mem_write & ~rst;
  assign dmem_re    = ctrl.mem_read & ~rst;

  // next PC
  assign pc_plus   = pc_q + XLEN'(WORD_BYTES);
  assign br_target = pc_plus + (imm_ext << 2);
  assign pc_next   = (ctrl.branch && alu_zero) ? br_target : pc_plus;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_next;
    end
  end

  assign imem_addr = pc_q;

  // R1: reset returns fetch to address zero
  a_r1_pc_reset: assert property (@(posedge clk)
    rst |=> (pc_q == '0));

  // R9: non-branch instructions step by one word
  a_r9_pc_step: assert property (@(posedge clk) disable iff (rst)
    (opcode != OPC_BEQ) |=> (pc_q == $past(pc_q) + XLEN'(WORD_BYTES)));

  // R8: equal operands redirect to the branch target
  a_r8_branch_taken: assert property (@(posedge clk) disable iff (rst)
    ((opcode == OPC_BEQ) && (rd_a == rd_b)) |=>
      (pc_q == $past(pc_q) + XLEN'(WORD_BYTES) + ($past(imm_ext) << 2)));

  // R6: post-increment store writes memory and the base in one cycle
  a_r6_store_and_bump: assert property (@(posedge clk) disable iff (rst)
    (opcode == OPC_SWINC) |->
      (dmem_we && rf_we && (rf_waddr == rs) &&
       (dmem_addr == rd_a + imm_ext) && (rf_wdata == rd_a + XLEN'(WORD_BYTES))));

  // R10: unknown opcodes leave all state alone
  a_r10_unknown_quiet: assert property (@(posedge clk) disable iff (rst)
    ((opcode != OPC_RTYPE) && (opcode != OPC_LW) && (opcode != OPC_SW) &&
     (opcode != OPC_SWINC) && (opcode != OPC_BEQ)) |-> (!dmem_we && !rf_we));

  // R4: loads read and never write memory
  a_r4_load_port: assert property (@(posedge clk) disable iff (rst)
    (opcode == OPC_LW) |-> (dmem_re && !dmem_we));

endmodule

// File: tb/autoinc_core_test.sv
`timescale 1ns/1ps
module autoinc_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, dmem_re;

  always #2 clk = ~clk;

  autoinc_core uut (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_re    (dmem_re),
    .dmem_rdata (dmem_rdata)
  );

  logic [31:0] imem [256];
  logic [31:0] dmem [256];
  string       hint [256];

  assign imem_data  = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[9:2]];

  always @(posedge clk) begin
    if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;
  end

  // reference model state
  logic [31:0] mr  [32];
  logic [31:0] mdm [256];
  logic [31:0] mpc;
  string       prev_tag;
  int          checks = 0;
  int          errors = 0;
  int          p;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rtype(input int rd, input int rs, input int rt,
                                        input logic [5:0] fn, input int sh);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction

  function automatic logic [31:0] itype(input logic [5:0] op, input int rt,
                                        input int rs, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic string tag_of(input logic [31:0] ins);
    logic [5:0] op = ins[31:26];
    logic [5:0] fn = ins[5:0];
    case (op)
      6'h00: begin
        if (ins[10:6] != 0) return "R10";
        if (fn == 6'h2A) return "R3";
        if (fn == 6'h20 || fn == 6'h22 || fn == 6'h24 || fn == 6'h25) return "R2";
        return "R10";
      end
      6'h23: return "R4";
      6'h2B: return (ins[20:16] == 0) ? "R7" : "R5";
      6'h2F: return (ins[25:21] == 0) ? "R7" : "R6";
      6'h04: return "R8";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [31:0] rand_ins();
    int r = $urandom_range(0, 99);
    int a = $urandom_range(0, 31);
    int b = $urandom_range(0, 31);
    int c = $urandom_range(0, 31);
    int im = $urandom_range(0, 65535);
    logic [5:0] fns [5] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
    logic [5:0] bad [3] = '{6'h3F, 6'h08, 6'h0D};
    if (r < 30) return rtype(c, a, b, fns[$urandom_range(0, 4)], 0);
    if (r < 45) return itype(6'h23, b, a, im);
    if (r < 60) return itype(6'h2B, b, a, im);
    if (r < 75) return itype(6'h2F, b, a, im);
    if (r < 85) return itype(6'h04, b, a, $urandom_range(0, 4));
    if (r < 92) return rtype(c, a, b, 6'h21, $urandom_range(0, 1));
    return itype(bad[$urandom_range(0, 2)], b, a, im);
  endfunction

  task automatic put(input logic [31:0] ins, input string h);
    imem[p] = ins;
    hint[p] = h;
    p++;
  endtask

  // compare one cycle against the model, then advance the model
  task automatic step();
    logic [31:0] ins, a, b, imm, addr, res, npc;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd, sh, dst;
    bit          wr, ew, er;
    string       tg;
    #1;
    ins = imem[mpc[9:2]];
    op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    sh = ins[10:6];  fn = ins[5:0];
    imm = {{16{ins[15]}}, ins[15:0]};
    a = mr[rs]; b = mr[rt]; addr = a + imm; npc = mpc + 4;
    wr = 0; ew = 0; er = 0; dst = 0; res = 0;
    tg = (hint[mpc[9:2]] != "") ? hint[mpc[9:2]] : tag_of(ins);
    case (op)
      6'h00: if (sh == 0) begin
        dst = rd; wr = 1;
        case (fn)
          6'h20: res = a + b;
          6'h22: res = a - b;
          6'h24: res = a & b;
          6'h25: res = a | b;
          6'h2A: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: wr = 0;
        endcase
      end
      6'h23: begin er = 1; wr = 1; dst = rt; res = mdm[addr[9:2]]; end
      6'h2B: ew = 1;
      6'h2F: begin ew = 1; wr = 1; dst = rs; res = a + 4; end
      6'h04: if (a == b) npc = mpc + 4 + (imm << 2);
      default: ;
    endcase
    chk(imem_addr == mpc, prev_tag, "pc", imem_addr, mpc);
    chk(dmem_we == ew, tg, "store strobe", {31'b0, dmem_we}, {31'b0, ew});
    if (ew) begin
      chk(dmem_addr == addr, tg, "store address", dmem_addr, addr);
      chk(dmem_wdata == b, tg, "store data", dmem_wdata, b);
    end
    if (er) begin
      chk(dmem_re == 1'b1, "R4", "load strobe", {31'b0, dmem_re}, 32'd1);
      chk(dmem_addr == addr, "R4", "load address", dmem_addr, addr);
    end
    if (ew) mdm[addr[9:2]] = b;
    if (wr && dst != 0) mr[dst] = res;
    prev_tag = (op == 6'h04) ? "R8" : "R9";
    mpc = npc;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end

  initial begin
    logic [31:0] seed_val;
    seed_val = $urandom(32'h00C0FFEE);
    for (int i = 0; i < 32; i++) mr[i] = 32'd0;
    for (int i = 0; i < 256; i++) begin
      dmem[i] = $urandom;
      hint[i] = "";
    end
    dmem[40] = 32'hFFFF_FFF0;
    dmem[41] = 32'd5;
    dmem[42] = 32'h0000_0100;
    for (int i = 0; i < 256; i++) mdm[i] = dmem[i];

    p = 0;
    for (int i = 1; i < 32; i++) put(itype(6'h23, i, 0, 4 * i), "R4");
    put(itype(6'h23, 9, 0, 160), "R4");
    put(itype(6'h23, 10, 0, 164), "R4");
    put(itype(6'h23, 13, 0, 168), "R4");
    put(rtype(1, 2, 3, 6'h20, 0), "R2"); put(itype(6'h2B, 1, 0, 'h300), "R2");
    put(rtype(4, 2, 3, 6'h22, 0), "R2"); put(itype(6'h2B, 4, 0, 'h304), "R2");
    put(rtype(5, 2, 3, 6'h24, 0), "R2"); put(itype(6'h2B, 5, 0, 'h308), "R2");
    put(rtype(6, 2, 3, 6'h25, 0), "R2"); put(itype(6'h2B, 6, 0, 'h30C), "R2");
    put(rtype(11, 9, 10, 6'h2A, 0), "R3"); put(itype(6'h2B, 11, 0, 'h310), "R3");
    put(rtype(12, 10, 9, 6'h2A, 0), "R3"); put(itype(6'h2B, 12, 0, 'h314), "R3");
    put(itype(6'h2F, 10, 13, 40), "R6");
    put(itype(6'h2F, 10, 13, 0), "R6");
    put(itype(6'h2B, 13, 0, 'h318), "R6");
    put(itype(6'h2F, 10, 0, 'h31C), "R7");
    put(itype(6'h2B, 0, 0, 'h320), "R7");
    put(rtype(0, 10, 10, 6'h20, 0), "R7"); put(itype(6'h2B, 0, 0, 'h324), "R7");
    put(itype(6'h3F, 10, 10, 'h55), "R10"); put(itype(6'h2B, 10, 0, 'h328), "R10");
    put(rtype(10, 10, 10, 6'h20, 3), "R10"); put(itype(6'h2B, 10, 0, 'h32C), "R10");
    put(itype(6'h04, 10, 10, 2), "R8");
    put(itype(6'h2B, 10, 0, 'h330), "R8");
    put(itype(6'h2B, 10, 0, 'h334), "R8");
    put(itype(6'h04, 10, 9, 3), "R8");
    put(itype(6'h2B, 10, 0, 'h338), "R8");
    while (p < 256) put(rand_ins(), "");

    mpc = 32'd0;
    prev_tag = "R1";
    repeat (3) @(negedge clk);
    #1;
    chk(imem_addr == 32'd0, "R1", "pc in reset", imem_addr, 32'd0);
    chk(dmem_we == 1'b0, "R1", "store strobe in reset", {31'b0, dmem_we}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    step();
    repeat (2999) begin
      @(negedge clk);
      step();
    end

    // mid-run reset, then dump every register through stores
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #1;
    chk(imem_addr == 32'd0, "R1", "pc after reset", imem_addr, 32'd0);
    chk(dmem_we == 1'b0, "R1", "store strobe in reset", {31'b0, dmem_we}, 32'd0);
    for (int i = 0; i < 256; i++) begin
      imem[i] = (i < 32) ? itype(6'h2B, i, 0, 'h200 + 4 * i) : rtype(0, 0, 0, 6'h20, 0);
      hint[i] = (i < 32) ? "R1" : "";
    end
    mpc = 32'd0;
    prev_tag = "R1";
    @(negedge clk);
    rst = 1'b0;
    step();
    repeat (40) begin
      @(negedge clk);
      step();
    end
    finish_run();
  end

endmodule